// File: doc/BRIEF.md
# Parallel-Input CRC Signature Checker

This block folds a stream of 16-bit data words into a 32-bit signature held in a linear feedback shift register. The feedback polynomial is programmable, so the usual CRC polynomials can be loaded. One word is absorbed per clock while the word strobe is high, and the result is the same as sixteen one-bit shifts taken from the most significant data bit down.

A word counter splits the stream into blocks of a programmable length. The first word of every block starts from a programmable seed. When the last word of a block arrives, the signature is latched as the block result. The result is then compared in hardware against a programmed reference value, and an interrupt pulse is raised on a mismatch if that pulse is enabled. A second mode lets the register run free as a pseudo-random source: it advances every clock with zero data, and a zero seed is replaced by one.

Settings are written through a small word-addressed write port. Address 0 is the polynomial, 1 the seed, 2 the block length, 3 the reference value and 4 the control word (bit 0 enables the interrupt, bit 1 selects the free-running mode). Any other address is ignored.

Top module: `crc_sig_checker`

## Requirements
- R1: The signature only changes on a clock where a word is taken (word strobe high, free-running mode off, no setting write) or where free-running mode is active with no setting write. On every other clock it holds its value.
- R2: A word is folded in as sixteen serial steps, data bit 15 first. In each step the feedback bit is the signature's bit 31 XOR the data bit, the signature shifts left by one, and the polynomial (address 0) is XORed in when the feedback bit is 1.
- R3: A new block starts after reset, after any setting write, and after the last word of a block. The first word of a new block is folded into the seed (address 1) rather than into the current signature.
- R4: A block holds L words, where L is the low 16 bits written to address 2. A value of 0 acts as 1.
- R5: One clock after the last word of a block is taken, `blk_done` is high for exactly one cycle and `result` shows that block's final signature. `result` then holds until the next block ends.
- R6: `blk_mismatch` is updated when a block ends. It is 1 when the final signature differs from the reference value (address 3), and it holds until the next block ends.
- R7: `irq` is a one-cycle pulse, raised together with `blk_done` only when the block mismatched and control bit 0 is 1.
- R8: With control bit 1 set, the signature advances every clock as if the data word were zero. The word strobe and data are ignored, and no block ever ends.
- R9: In free-running mode a zero seed is replaced by the value 1.
- R10: A setting write on the same clock as a word strobe wins: that word is dropped and is not folded in.
- R11: After reset, `sig_out`, `result`, `blk_done`, `blk_mismatch` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 3 | Setting address (0 polynomial, 1 seed, 2 length, 3 reference, 4 control) |
| cfg_wdata | input | 32 | Setting write data |
| data_valid | input | 1 | Word strobe |
| data_in | input | 16 | Data word |
| sig_out | output | 32 | Current signature |
| result | output | 32 | Latched signature of the last finished block |
| blk_done | output | 1 | One-cycle pulse at block end |
| blk_mismatch | output | 1 | Last finished block differed from the reference value |
| irq | output | 1 | One-cycle mismatch interrupt pulse |

## Verification
The hardest situations to reach from the ports are the edges of a block. These are a setting write that lands on the same clock as a word, the length value of zero, and back-to-back blocks where the next block's first word has to restart from the seed with no idle clock in between. The bench drives each of these directly. It predicts every signature with its own bit-serial model and checks the signature after every word, not only at the block end. Free-running mode is checked with a zero seed while the word strobe is deliberately toggled, so that any data leaking in would change the sequence.

// File: rtl/crc_sig_pkg.sv
package crc_sig_pkg;
  localparam int SIG_W = 32;
  localparam int DAT_W = 16;
  localparam int CNT_W = 16;
  localparam int ADR_W = 3;

  typedef enum logic [ADR_W-1:0] {
    ADR_POLY = 3'd0,
    ADR_SEED = 3'd1,
    ADR_LEN  = 3'd2,
    ADR_REF  = 3'd3,
    ADR_CTRL = 3'd4
  } cfg_adr_e;

  localparam int CTRL_IRQ_EN = 0;
  localparam int CTRL_PRNG   = 1;
endpackage

// File: rtl/crc_sig_step.sv
module crc_sig_step #(
  parameter int SW = 32,
  parameter int DW = 16
) (
  input  logic [SW-1:0] crc_in,
  input  logic [DW-1:0] din,
  input  logic [SW-1:0] poly,
  output logic [SW-1:0] crc_out
);
  logic [SW-1:0] acc;
  logic          fb;

  // DW serial steps unrolled, top data bit first.
  always_comb begin
    acc = crc_in;
    fb  = 1'b0;
    for (int i = DW - 1; i >= 0; i--) begin
      fb  = acc[SW-1] ^ din[i];
      acc = {acc[SW-2:0], 1'b0} ^ (fb ? poly : '0);
    end
    crc_out = acc;
  end
endmodule

// File: rtl/crc_sig_cfg.sv
module crc_sig_cfg
  import crc_sig_pkg::*;
#(
  parameter logic [SIG_W-1:0] POLY_RST = 32'h04C1_1DB7,
  parameter logic [SIG_W-1:0] SEED_RST = 32'hFFFF_FFFF,
  parameter logic [CNT_W-1:0] LEN_RST  = 16'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [ADR_W-1:0] addr,
  input  logic [SIG_W-1:0] wdata,
  output logic [SIG_W-1:0] poly,
  output logic [SIG_W-1:0] seed,
  output logic [CNT_W-1:0] blk_len,
  output logic [SIG_W-1:0] ref_val,
  output logic             irq_en,
  output logic             prng
);
  logic [SIG_W-1:0] poly_d, seed_d, ref_d;
  logic [CNT_W-1:0] len_d;
  logic             irq_en_d, prng_d;

  always_comb begin
    poly_d   = poly;
    seed_d   = seed;
    len_d    = blk_len;
    ref_d    = ref_val;
    irq_en_d = irq_en;
    prng_d   = prng;
    if (we) begin
      unique case (addr)
        ADR_POLY: poly_d = wdata;
        ADR_SEED: seed_d = wdata;
        ADR_LEN:  len_d  = wdata[CNT_W-1:0];
        ADR_REF:  ref_d  = wdata;
        ADR_CTRL: begin
          irq_en_d = wdata[CTRL_IRQ_EN];
          prng_d   = wdata[CTRL_PRNG];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poly    <= POLY_RST;
      seed    <= SEED_RST;
      blk_len <= LEN_RST;
      ref_val <= '0;
      irq_en  <= 1'b0;
      prng    <= 1'b0;
    end else if (we) begin
      poly    <= poly_d;
      seed    <= seed_d;
      blk_len <= len_d;
      ref_val <= ref_d;
      irq_en  <= irq_en_d;
      prng    <= prng_d;
    end
  end
endmodule

// File: rtl/crc_sig_core.sv
module crc_sig_core
  import crc_sig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             data_valid,
  input  logic [DAT_W-1:0] data_in,
  input  logic [SIG_W-1:0] poly,
  input  logic [SIG_W-1:0] seed,
  input  logic [CNT_W-1:0] blk_len,
  input  logic [SIG_W-1:0] ref_val,
  input  logic             irq_en,
  input  logic             prng,
  output logic [SIG_W-1:0] sig_q,
  output logic [SIG_W-1:0] res_q,
  output logic             done_q,
  output logic             mis_q,
  output logic             irq_q
);
  logic [SIG_W-1:0] sig_d, res_d, start_val, base, step_out;
  logic [DAT_W-1:0] step_din;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;
  logic             fresh_q, fresh_d, last, done_d, mis_d, irq_d, differ;

  crc_sig_step #(.SW(SIG_W), .DW(DAT_W)) step_i (
    .crc_in (base),
    .din    (step_din),
    .poly   (poly),
    .crc_out(step_out)
  );

  always_comb begin
    start_val = (prng && seed == '0) ? SIG_W'(1) : seed;
    base      = fresh_q ? start_val : sig_q;
    step_din  = prng ? '0 : data_in;
    cnt_inc   = {1'b0, cnt_q} + 1'b1;
    last      = cnt_inc >= {1'b0, blk_len};
    differ    = step_out != ref_val;

    sig_d   = sig_q;
    res_d   = res_q;
    mis_d   = mis_q;
    cnt_d   = cnt_q;
    fresh_d = fresh_q;
    done_d  = 1'b0;
    irq_d   = 1'b0;
    if (cfg_we) begin
      fresh_d = 1'b1;
      cnt_d   = '0;
    end else if (prng) begin
      sig_d   = step_out;
      fresh_d = 1'b0;
    end else if (data_valid) begin
      sig_d = step_out;
      if (last) begin
        fresh_d = 1'b1;
        cnt_d   = '0;
        res_d   = step_out;
        mis_d   = differ;
        done_d  = 1'b1;
        irq_d   = irq_en && differ;
      end else begin
        fresh_d = 1'b0;
        cnt_d   = cnt_inc[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q   <= '0;
      res_q   <= '0;
      mis_q   <= 1'b0;
      cnt_q   <= '0;
      fresh_q <= 1'b1;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      sig_q   <= sig_d;
      res_q   <= res_d;
      mis_q   <= mis_d;
      cnt_q   <= cnt_d;
      fresh_q <= fresh_d;
      done_q  <= done_d;
      irq_q   <= irq_d;
    end
  end

  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we || (!data_valid && !prng)) |=> $stable(sig_q));

  assert_done_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (fresh_q && cnt_q == '0));

  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) || ({1'b0, cnt_q} < {1'b0, blk_len}));

  assert_irq_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (done_q && mis_q));

  assert_prng_no_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prng && !cfg_we) |=> !done_q);

  assert_prng_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (prng && !cfg_we && poly[0]) |=> (sig_q != '0));
endmodule

// File: rtl/crc_sig_checker.sv
module crc_sig_checker
  import crc_sig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [ADR_W-1:0] cfg_addr,
  input  logic [SIG_W-1:0] cfg_wdata,
  input  logic             data_valid,
  input  logic [DAT_W-1:0] data_in,
  output logic [SIG_W-1:0] sig_out,
  output logic [SIG_W-1:0] result,
  output logic             blk_done,
  output logic             blk_mismatch,
  output logic             irq
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_i;
  logic [SIG_W-1:0] poly, seed, ref_val;
  logic [CNT_W-1:0] blk_len;
  logic             irq_en, prng;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  crc_sig_cfg cfg_i (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .poly   (poly),
    .seed   (seed),
    .blk_len(blk_len),
    .ref_val(ref_val),
    .irq_en (irq_en),
    .prng   (prng)
  );

  crc_sig_core core_i (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .cfg_we    (cfg_we),
    .data_valid(data_valid),
    .data_in   (data_in),
    .poly      (poly),
    .seed      (seed),
    .blk_len   (blk_len),
    .ref_val   (ref_val),
    .irq_en    (irq_en),
    .prng      (prng),
    .sig_q     (sig_out),
    .res_q     (result),
    .done_q    (blk_done),
    .mis_q     (blk_mismatch),
    .irq_q     (irq)
  );
endmodule

// File: tb/crc_sig_checker_tb.sv
module crc_sig_checker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        data_valid;
  logic [15:0] data_in;
  logic [31:0] sig_out, result;
  logic        blk_done, blk_mismatch, irq;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  crc_sig_checker dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .data_valid(data_valid), .data_in(data_in),
    .sig_out(sig_out), .result(result), .blk_done(blk_done),
    .blk_mismatch(blk_mismatch), .irq(irq)
  );

  typedef struct packed {
    logic [31:0] poly;
    logic [31:0] seed;
    logic [15:0] len;
    logic [15:0] first;
    logic [15:0] stride;
    logic        bad;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{poly: 32'h04C1_1DB7, seed: 32'hFFFF_FFFF, len: 16'd3, first: 16'h1234, stride: 16'h1111, bad: 1'b0},
    '{poly: 32'h1EDC_6F41, seed: 32'h0000_0000, len: 16'd1, first: 16'hA5A5, stride: 16'h0000, bad: 1'b1},
    '{poly: 32'h741B_8CD7, seed: 32'h1357_9BDF, len: 16'd5, first: 16'hFFFF, stride: 16'hF00D, bad: 1'b1},
    '{poly: 32'h8140_4003, seed: 32'hDEAD_BEEF, len: 16'd8, first: 16'h0001, stride: 16'h0203, bad: 1'b0}
  };

  function automatic logic [31:0] ref_fold(logic [31:0] c, logic [15:0] d, logic [31:0] p);
    logic [31:0] r = c;
    for (int b = 15; b >= 0; b--) begin
      if (r[31] ^ d[b]) r = (r << 1) ^ p;
      else              r = r << 1;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic word(input logic [15:0] d);
    data_valid = 1'b1; data_in = d;
    @(negedge clk);
    data_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] exp_sig, final_sig, held;
    logic [15:0] d;
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; data_valid = 0; data_in = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R11 reset state
    chk(sig_out == 0 && result == 0, "R11 sig/result", sig_out, 0);
    chk(!blk_done && !blk_mismatch && !irq, "R11 flags", {blk_done, blk_mismatch, irq}, 0);

    // Table walk: R2 R4 R5 R6 R7
    foreach (VECS[v]) begin
      final_sig = VECS[v].seed;
      d = VECS[v].first;
      for (int k = 0; k < int'(VECS[v].len); k++) begin
        final_sig = ref_fold(final_sig, d, VECS[v].poly);
        d = d + VECS[v].stride;
      end
      wr(3'd0, VECS[v].poly);
      wr(3'd1, VECS[v].seed);
      wr(3'd2, {16'd0, VECS[v].len});
      wr(3'd3, VECS[v].bad ? ~final_sig : final_sig);
      wr(3'd4, 32'h1);
      exp_sig = VECS[v].seed;
      d = VECS[v].first;
      for (int k = 0; k < int'(VECS[v].len); k++) begin
        exp_sig = ref_fold(exp_sig, d, VECS[v].poly);
        word(d);
        d = d + VECS[v].stride;
        chk(sig_out == exp_sig, "R2 signature per word", sig_out, exp_sig);
        if (k < int'(VECS[v].len) - 1)
          chk(!blk_done, "R4 no done before last word", {31'd0, blk_done}, 0);
      end
      chk(blk_done, "R5 done pulse", {31'd0, blk_done}, 1);
      chk(result == final_sig, "R5 result", result, final_sig);
      chk(blk_mismatch == VECS[v].bad, "R6 mismatch", {31'd0, blk_mismatch}, {31'd0, VECS[v].bad});
      chk(irq == VECS[v].bad, "R7 irq", {31'd0, irq}, {31'd0, VECS[v].bad});
      @(negedge clk);
      chk(!blk_done && !irq, "R5 pulse one cycle", {30'd0, blk_done, irq}, 0);
      chk(result == final_sig, "R5 result held", result, final_sig);
    end

    // R7: mismatch with interrupt disabled gives no irq
    wr(3'd2, 32'd1);
    wr(3'd3, 32'h0);
    wr(3'd4, 32'h0);
    word(16'h5555);
    chk(blk_done && blk_mismatch && !irq, "R7 irq masked", {29'd0, blk_done, blk_mismatch, irq}, 32'h6);

    // R4: length zero acts as one; R3 back-to-back blocks restart from seed
    wr(3'd0, 32'h04C1_1DB7);
    wr(3'd1, 32'hCAFE_F00D);
    wr(3'd2, 32'd0);
    exp_sig = ref_fold(32'hCAFE_F00D, 16'h0F0F, 32'h04C1_1DB7);
    word(16'h0F0F);
    chk(blk_done && result == exp_sig, "R4 length zero is one word", result, exp_sig);
    wr(3'd2, 32'd2);
    word(16'h1111); word(16'h2222);
    exp_sig = ref_fold(32'hCAFE_F00D, 16'h3333, 32'h04C1_1DB7);
    word(16'h3333);
    chk(sig_out == exp_sig, "R3 next block starts from seed", sig_out, exp_sig);
    exp_sig = ref_fold(exp_sig, 16'h4444, 32'h04C1_1DB7);
    word(16'h4444);
    chk(blk_done && result == exp_sig, "R3 second block result", result, exp_sig);

    // R1: idle clocks hold the signature mid-block
    word(16'h7777);
    held = sig_out;
    repeat (3) @(negedge clk);
    chk(sig_out == held, "R1 idle hold", sig_out, held);
    exp_sig = ref_fold(held, 16'h8888, 32'h04C1_1DB7);
    word(16'h8888);
    chk(blk_done && result == exp_sig, "R1 resume after idle", result, exp_sig);

    // R10: setting write on the same clock as a word drops the word
    data_valid = 1'b1; data_in = 16'hBAD0;
    wr(3'd3, 32'h1);
    data_valid = 1'b0;
    word(16'h0102);
    exp_sig = ref_fold(ref_fold(32'hCAFE_F00D, 16'h0102, 32'h04C1_1DB7), 16'h0304, 32'h04C1_1DB7);
    word(16'h0304);
    chk(blk_done && result == exp_sig, "R10 colliding word dropped", result, exp_sig);

    // R8 R9: free-running mode, zero seed, strobe toggling ignored
    wr(3'd1, 32'h0);
    wr(3'd4, 32'h2);
    exp_sig = 32'h1;
    for (int k = 0; k < 6; k++) begin
      data_valid = k[0]; data_in = 16'hFFFF;
      exp_sig = ref_fold(exp_sig, 16'h0, 32'h04C1_1DB7);
      @(negedge clk);
      chk(sig_out == exp_sig, k == 0 ? "R9 zero seed replaced" : "R8 free-run step", sig_out, exp_sig);
      chk(!blk_done, "R8 no block end", {31'd0, blk_done}, 0);
    end
    data_valid = 1'b0;
    wr(3'd4, 32'h0);

    finish_run();
  end
endmodule